// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between a client that wants whole flash operations done and a byte-wide SPI master that moves one byte per transfer. A single request names an operation, a 24-bit address and a byte count. The sequencer then produces every chip-select frame the flash needs. It first waits for the device to go idle by reading its status register. For any program or erase it sends a write-enable frame of its own. It then sends the command frame with its address, its program data or its read data. Program data arrives on a valid/ready stream and read data leaves on another.

The busy wait runs at the start of each operation rather than at the end, so a long erase overlaps whatever the client does next. A mode input picks between two bus disciplines. In shared-bus mode every status read is a short frame of its own, and a programmable idle gap follows each one so other devices can use the bus. In exclusive mode one frame stays selected and the status byte is clocked out repeatedly. The bit-level serial timing belongs to the byte master, which is outside this block.

Top module: `spi_nor_sequencer`

## Requirements
- R1: While and after reset, with no request, `cs_n` is 1, `req_ready` is 1, `xfer_go` is 0 and `rd_valid` is 0.
- R2: Every accepted operation begins with a status wait. In shared-bus mode (`excl_bus`=0) each poll is its own frame of the bytes 0x05, 0xA5. Polls repeat while bit 0 of the byte returned for 0xA5 is 1. Between two poll frames `cs_n` stays high for at least `POLL_GAP` cycles.
- R3: In exclusive mode (`excl_bus`=1) the status wait is one frame: 0x05, then 0xA5 repeated until a returned byte has bit 0 clear.
- R4: Program and erase operations get a separate frame holding only 0x06, placed between the status wait and the command frame. A read gets no such frame.
- R5: Page program (`req_op`=1) sends one frame: 0x02, then three address bytes with the most significant first, then `req_len`+1 bytes taken in order from the write stream. `wr_ready` is high only while that frame is open.
- R6: Sector erase (`req_op`=2) sends 0xD8 and sub-sector erase (`req_op`=3) sends 0x20, each followed by three address bytes with the most significant first, in a single frame.
- R7: Bulk erase (`req_op`=4) sends a command frame holding only 0xC7.
- R8: Read (`req_op`=0) sends 0x03, three address bytes with the most significant first, and `req_len`+1 filler bytes 0xA5, all in one frame. The byte returned for each filler appears in order on `rd_data`. A held byte stays stable until it is taken. No further filler is started while a byte is still held.
- R9: `req_ready` falls on acceptance and stays low until the edge where the last frame of the operation is released. `req_op` codes 5 to 7 are taken with `req_ready` still high and cause no frame.
- R10: `xfer_go` is a one-cycle pulse, given only while `cs_n` is 0. At most one byte transfer is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| excl_bus | input | 1 | 1: poll in one held frame; 0: one frame per poll with idle gaps |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | 0 read, 1 page program, 2 sector erase, 3 sub-sector erase, 4 bulk erase |
| req_addr | input | ADDR_W | Flash byte address |
| req_len | input | LEN_W | Byte count minus one for read or program |
| wr_valid | input | 1 | Program byte offered |
| wr_data | input | 8 | Program byte |
| wr_ready | output | 1 | Program byte taken this cycle if offered |
| rd_valid | output | 1 | Read byte held |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer takes the held byte |
| cs_n | output | 1 | Flash select, active low |
| xfer_go | output | 1 | Start one byte transfer |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Byte transfer finished |
| xfer_rx | input | 8 | Byte shifted in during that transfer |

## Verification
The assertions assume that the byte master raises `xfer_done` exactly once for each `xfer_go`, some cycles later, and never on its own. They also assume that `excl_bus` changes only while no operation is in flight. The stimulus keeps to both: the bench's master returns each byte a fixed three cycles after the pulse, and the mode is set only in the idle cycle before a request is offered. Status busy counts, write-stream gaps and read back-pressure are all varied so that polling repeats, program bytes stall and held read bytes wait.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam logic [2:0] OP_READ     = 3'd0;
  localparam logic [2:0] OP_PROG     = 3'd1;
  localparam logic [2:0] OP_SECT     = 3'd2;
  localparam logic [2:0] OP_SUBSECT  = 3'd3;
  localparam logic [2:0] OP_BULK     = 3'd4;

  localparam logic [7:0] CMD_STATUS  = 8'h05;
  localparam logic [7:0] CMD_FILL    = 8'hA5;
  localparam logic [7:0] CMD_WREN    = 8'h06;
  localparam logic [7:0] CMD_READ    = 8'h03;
  localparam logic [7:0] CMD_PROG    = 8'h02;
  localparam logic [7:0] CMD_SECT    = 8'hD8;
  localparam logic [7:0] CMD_SUBSECT = 8'h20;
  localparam logic [7:0] CMD_BULK    = 8'hC7;

  // busy flag position inside the returned status byte
  localparam int unsigned SR_BUSY_BIT = 0;

  typedef struct packed {
    logic [7:0] opcode;
    logic       has_addr;
    logic       need_wren;
    logic       is_read;
    logic       is_prog;
  } sfs_cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_CMD,
    ST_POLL_FILL,
    ST_POLL_WAIT,
    ST_SPACE,
    ST_WREN,
    ST_OPC,
    ST_ADDR,
    ST_WR,
    ST_RD
  } sfs_state_e;

endpackage

// File: rtl/sfs_op_decode.sv
module sfs_op_decode
  import sfs_pkg::*;
(
  input  logic [2:0] op,
  output logic       legal,
  output sfs_cmd_t   cmd
);

  always_comb begin
    legal = 1'b1;
    cmd   = '0;
    case (op)
      OP_READ: begin
        cmd.opcode   = CMD_READ;
        cmd.has_addr = 1'b1;
        cmd.is_read  = 1'b1;
      end
      OP_PROG: begin
        cmd.opcode    = CMD_PROG;
        cmd.has_addr  = 1'b1;
        cmd.need_wren = 1'b1;
        cmd.is_prog   = 1'b1;
      end
      OP_SECT: begin
        cmd.opcode    = CMD_SECT;
        cmd.has_addr  = 1'b1;
        cmd.need_wren = 1'b1;
      end
      OP_SUBSECT: begin
        cmd.opcode    = CMD_SUBSECT;
        cmd.has_addr  = 1'b1;
        cmd.need_wren = 1'b1;
      end
      OP_BULK: begin
        cmd.opcode    = CMD_BULK;
        cmd.need_wren = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sfs_gap_timer.sv
module sfs_gap_timer #(
  parameter int GAP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic elapsed
);

  localparam int CW = $clog2(GAP + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != CW'(GAP)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign elapsed = (cnt == CW'(GAP));

  // R2: the count never passes the programmed gap
  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(GAP));

endmodule

// File: rtl/sfs_rd_hold.sv
module sfs_rd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic         v_q;
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (push) begin
      v_q <= 1'b1;
    end else if (v_q && out_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      d_q <= din;
    end
  end

  assign full      = v_q;
  assign out_valid = v_q;
  assign out_data  = d_q;

  // R8: a new byte never lands on an untaken one
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !v_q);

  // R8: a held byte stays put until taken
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (v_q && !out_ready) |=> (v_q && $stable(d_q)));

endmodule

// File: rtl/spi_nor_sequencer.sv
module spi_nor_sequencer
  import sfs_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 8,
  parameter int POLL_GAP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excl_bus,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              rd_ready,
  output logic              cs_n,
  output logic              xfer_go,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx
);

  localparam int ADDR_BYTES = ADDR_W / 8;

  sfs_state_e        st, nxt_q;
  sfs_cmd_t          cmd_q, dec_cmd;
  logic              dec_legal;
  logic              cs_n_q, go_q, pend, ready_q;
  logic [7:0]        tx_q;
  logic [LEN_W-1:0]  bcnt, len_q;
  logic [ADDR_W-1:0] addr_q;
  logic              gap_done, hold_full, hold_push;
  logic [1:0]        outst;

  sfs_op_decode u_dec (
    .op    (req_op),
    .legal (dec_legal),
    .cmd   (dec_cmd)
  );

  sfs_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .run     (st == ST_POLL_WAIT),
    .elapsed (gap_done)
  );

  assign hold_push = (st == ST_RD) && pend && xfer_done;

  sfs_rd_hold #(.W(8)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .push      (hold_push),
    .din       (xfer_rx),
    .full      (hold_full),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .out_ready (rd_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cmd_q   <= '0;
      cs_n_q  <= 1'b1;
      go_q    <= 1'b0;
      tx_q    <= '0;
      pend    <= 1'b0;
      ready_q <= 1'b1;
      bcnt    <= '0;
      len_q   <= '0;
      addr_q  <= '0;
    end else begin
      go_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid && ready_q && dec_legal) begin
            ready_q <= 1'b0;
            cmd_q   <= dec_cmd;
            addr_q  <= req_addr;
            len_q   <= req_len;
            st      <= ST_POLL_CMD;
          end
        end
        ST_POLL_CMD: begin
          if (!pend) begin
            cs_n_q <= 1'b0;
            go_q   <= 1'b1;
            tx_q   <= CMD_STATUS;
            pend   <= 1'b1;
          end else if (xfer_done) begin
            pend <= 1'b0;
            st   <= ST_POLL_FILL;
          end
        end
        ST_POLL_FILL: begin
          if (!pend) begin
            go_q <= 1'b1;
            tx_q <= CMD_FILL;
            pend <= 1'b1;
          end else if (xfer_done) begin
            pend <= 1'b0;
            if (!xfer_rx[SR_BUSY_BIT]) begin
              cs_n_q <= 1'b1;
              st     <= ST_SPACE;
              nxt_q  <= cmd_q.need_wren ? ST_WREN : ST_OPC;
            end else if (!excl_bus) begin
              cs_n_q <= 1'b1;
              st     <= ST_POLL_WAIT;
            end
          end
        end
        ST_POLL_WAIT: begin
          if (gap_done) begin
            st <= ST_POLL_CMD;
          end
        end
        ST_SPACE: begin
          st <= nxt_q;
        end
        ST_WREN: begin
          if (!pend) begin
            cs_n_q <= 1'b0;
            go_q   <= 1'b1;
            tx_q   <= CMD_WREN;
            pend   <= 1'b1;
          end else if (xfer_done) begin
            pend   <= 1'b0;
            cs_n_q <= 1'b1;
            st     <= ST_SPACE;
            nxt_q  <= ST_OPC;
          end
        end
        ST_OPC: begin
          if (!pend) begin
            cs_n_q <= 1'b0;
            go_q   <= 1'b1;
            tx_q   <= cmd_q.opcode;
            pend   <= 1'b1;
          end else if (xfer_done) begin
            pend <= 1'b0;
            bcnt <= '0;
            if (cmd_q.has_addr) begin
              st <= ST_ADDR;
            end else begin
              cs_n_q  <= 1'b1;
              ready_q <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
        ST_ADDR: begin
          if (!pend) begin
            go_q   <= 1'b1;
            tx_q   <= addr_q[ADDR_W-1 -: 8];
            addr_q <= addr_q << 8;
            pend   <= 1'b1;
          end else if (xfer_done) begin
            pend <= 1'b0;
            if (bcnt == LEN_W'(ADDR_BYTES - 1)) begin
              bcnt <= '0;
              if (cmd_q.is_read) begin
                st <= ST_RD;
              end else if (cmd_q.is_prog) begin
                st <= ST_WR;
              end else begin
                cs_n_q  <= 1'b1;
                ready_q <= 1'b1;
                st      <= ST_IDLE;
              end
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_WR: begin
          if (!pend) begin
            if (wr_valid) begin
              go_q <= 1'b1;
              tx_q <= wr_data;
              pend <= 1'b1;
            end
          end else if (xfer_done) begin
            pend <= 1'b0;
            if (bcnt == len_q) begin
              cs_n_q  <= 1'b1;
              ready_q <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (!pend) begin
            if (!hold_full) begin
              go_q <= 1'b1;
              tx_q <= CMD_FILL;
              pend <= 1'b1;
            end
          end else if (xfer_done) begin
            pend <= 1'b0;
            if (bcnt == len_q) begin
              cs_n_q  <= 1'b1;
              ready_q <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign wr_ready  = (st == ST_WR) && !pend;
  assign cs_n      = cs_n_q;
  assign xfer_go   = go_q;
  assign xfer_tx   = tx_q;

  // transfers in flight, seen from the pins only
  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= '0;
    end else begin
      outst <= outst + {1'b0, go_q} - {1'b0, xfer_done};
    end
  end

  // R10: a byte is started only inside a frame
  assert_go_framed_R10: assert property (@(posedge clk) disable iff (rst)
    go_q |-> !cs_n_q);

  // R10: never two bytes outstanding
  assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (rst)
    outst <= 2'd1);

  // R9: no new request while a frame is open
  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> !ready_q);

  // R2: each frame opens together with its first byte
  assert_frame_opens_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> go_q);

  // R5: program data is only taken inside the command frame
  assert_wr_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !cs_n_q);

  // R8: no filler starts while a read byte is still held
  assert_rd_no_prefetch_R8: assert property (@(posedge clk) disable iff (rst)
    (go_q && st == ST_RD) |-> !rd_valid);

endmodule

// File: tb/sim_spi_nor_sequencer.sv
`timescale 1ns/1ps
module sim_spi_nor_sequencer;

  localparam int GAP = 6;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        excl_bus = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        rd_ready = 1'b0;
  logic        cs_n;
  logic        xfer_go;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = '0;

  always #2.5 clk = ~clk;

  spi_nor_sequencer #(.POLL_GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .excl_bus(excl_bus),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .cs_n(cs_n), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int vec = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a ^ (a >> 8) ^ 'h3C) & 'hFF);
  endfunction

  // flash + byte master model and stream endpoints, all at the falling edge
  int         lat = 0;
  logic [7:0] rxp = '0;
  int         fidx = 0;
  logic [7:0] fop = '0;
  int         faddr = 0;
  int         busy_left = 0;
  int         cap[$];
  bit         cs_prev = 1'b1;
  int         rise_cyc = 0;
  int         gap_last = 0;
  bit         last_poll = 1'b0;
  int         wq[$];
  bit         wtook = 1'b0;
  int         rgot[$];
  bit         rhold = 1'b0;
  logic [7:0] rhold_d = '0;
  bit         model_on = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      vec++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
    if (model_on) begin
      // byte master
      xfer_done = 1'b0;
      if (xfer_go) chk(lat == 0, "R10 overlap", lat, 0);
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          xfer_done = 1'b1;
          xfer_rx   = rxp;
        end
      end
      // frame capture
      if (cs_n && !cs_prev) begin
        cap.push_back(256);
        rise_cyc = cyc;
      end
      if (!cs_n && cs_prev) begin
        fidx = 0;
        gap_last = cyc - rise_cyc;
      end
      if (!cs_n) chk(!req_ready, "R9 ready in frame", req_ready, 0);
      if (wr_ready) chk(!cs_n, "R5 wr_ready outside frame", cs_n, 0);
      if (xfer_go) begin
        chk(!cs_n, "R10 go outside frame", cs_n, 0);
        cap.push_back(int'(xfer_tx));
        rxp = 8'hFF;
        if (fidx == 0) begin
          fop = xfer_tx;
          if (xfer_tx == 8'h05 && !excl_bus && last_poll)
            chk(gap_last >= GAP, "R2 poll gap", gap_last, GAP);
          last_poll = (xfer_tx == 8'h05);
        end else if (fop == 8'h05) begin
          rxp = (busy_left > 0) ? 8'h03 : 8'h02;
          if (busy_left > 0) busy_left--;
        end else if (fop == 8'h03 && fidx <= 3) begin
          faddr = ((faddr << 8) | int'(xfer_tx)) & 'hFFFFFF;
        end else if (fop == 8'h03) begin
          chk(!rd_valid, "R8 filler while byte held", rd_valid, 0);
          rxp = pat(faddr + fidx - 4);
        end
        fidx++;
        lat = LAT;
      end
      cs_prev = cs_n;
      // program stream source
      if (wtook) void'(wq.pop_front());
      wr_valid = (wq.size() > 0) && (cyc % 3 != 0);
      wr_data  = (wq.size() > 0) ? 8'(wq[0]) : 8'h00;
      wtook    = wr_valid && wr_ready;
      // read stream sink
      if (rhold) begin
        chk(rd_valid, "R8 held byte dropped", rd_valid, 1);
        chk(rd_data == rhold_d, "R8 held byte changed", rd_data, rhold_d);
      end
      rd_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
      if (rd_valid && rd_ready) rgot.push_back(int'(rd_data));
      rhold   = rd_valid && !rd_ready;
      rhold_d = rd_data;
    end
  end

  task automatic push_frame(ref int e[$], ref string t[$], input int b, input string tag);
    e.push_back(b);
    t.push_back(tag);
  endtask

  task automatic run_op(input int op, input int addr, input int len, input int busy,
                        input bit excl, input int seed);
    int    exp[$];
    string tg[$];
    string ptag;
    string ctag;
    int    guard;
    int    n;
    @(negedge clk);
    excl_bus  = excl;
    busy_left = busy;
    cap.delete();
    rgot.delete();
    ptag = excl ? "R3" : "R2";
    if (excl) begin
      push_frame(exp, tg, 'h05, ptag);
      for (int i = 0; i <= busy; i++) push_frame(exp, tg, 'hA5, ptag);
      push_frame(exp, tg, 256, ptag);
    end else begin
      for (int i = 0; i <= busy; i++) begin
        push_frame(exp, tg, 'h05, ptag);
        push_frame(exp, tg, 'hA5, ptag);
        push_frame(exp, tg, 256, ptag);
      end
    end
    if (op != 0) begin
      push_frame(exp, tg, 'h06, "R4");
      push_frame(exp, tg, 256, "R4");
    end
    case (op)
      0: begin ctag = "R8"; push_frame(exp, tg, 'h03, ctag); end
      1: begin ctag = "R5"; push_frame(exp, tg, 'h02, ctag); end
      2: begin ctag = "R6"; push_frame(exp, tg, 'hD8, ctag); end
      3: begin ctag = "R6"; push_frame(exp, tg, 'h20, ctag); end
      default: begin ctag = "R7"; push_frame(exp, tg, 'hC7, ctag); end
    endcase
    if (op != 4) begin
      push_frame(exp, tg, (addr >> 16) & 'hFF, ctag);
      push_frame(exp, tg, (addr >> 8) & 'hFF, ctag);
      push_frame(exp, tg, addr & 'hFF, ctag);
    end
    if (op == 1) begin
      for (int i = 0; i <= len; i++) begin
        wq.push_back((i * 7 + seed) & 'hFF);
        push_frame(exp, tg, (i * 7 + seed) & 'hFF, ctag);
      end
    end
    if (op == 0) begin
      for (int i = 0; i <= len; i++) push_frame(exp, tg, 'hA5, ctag);
    end
    push_frame(exp, tg, 256, ctag);

    req_valid = 1'b1;
    req_op    = 3'(op);
    req_addr  = 24'(addr);
    req_len   = 8'(len);
    chk(req_ready == 1'b1, "R9 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready after accept", req_ready, 0);
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(req_ready && cs_n && (op != 0 || rgot.size() == len + 1)) && guard < 20000);
    @(negedge clk);

    chk(cap.size() == exp.size(), {ctag, " frame length"}, cap.size(), exp.size());
    n = (cap.size() < exp.size()) ? cap.size() : exp.size();
    for (int i = 0; i < n; i++) chk(cap[i] == exp[i], tg[i], cap[i], exp[i]);
    if (op == 0) begin
      chk(rgot.size() == len + 1, "R8 read count", rgot.size(), len + 1);
      for (int i = 0; i < rgot.size(); i++)
        chk(rgot[i] == int'(pat(addr + i)), "R8 read data", rgot[i], pat(addr + i));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(xfer_go == 1'b0, "R1 xfer_go", xfer_go, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    model_on = 1'b1;
    @(negedge clk);

    run_op(0, 'h123456, 3, 2, 1'b0, 0);
    run_op(1, 'h00AB00, 7, 0, 1'b0, 'h11);
    run_op(2, 'h3F0000, 0, 3, 1'b1, 0);
    run_op(3, 'h001000, 0, 1, 1'b0, 0);
    run_op(4, 0, 0, 0, 1'b1, 0);
    run_op(0, 'hFFFFFF, 0, 2, 1'b1, 0);
    run_op(1, 'h020000, 255, 1, 1'b1, 'h40);
    run_op(0, 'h0800F0, 255, 0, 1'b0, 0);
    run_op(4, 0, 0, 4, 1'b0, 0);

    // R9 illegal operation codes are consumed without traffic
    cap.delete();
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 3'd6;
    @(negedge clk);
    req_op    = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b1, "R9 illegal op ready", req_ready, 1);
    repeat (20) @(negedge clk);
    chk(cap.size() == 0, "R9 illegal op traffic", cap.size(), 0);
    chk(cs_n == 1'b1, "R9 illegal op cs_n", cs_n, 1);

    // a legal request right after still works
    run_op(3, 'h7FF000, 0, 0, 1'b0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule